// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block is the byte-level sequencer for sending an in-frame response (IFR) on a J1850-style serial bus. The host loads bytes into a one-byte data holder and arms a request while a frame is still being received. It can ask for an IFR that ends with a CRC byte or one that ends without a CRC. When the frame's end-of-data (EOD) symbol arrives and its CRC checked good, the sequencer drives a symbol-level transmitter through a request/acknowledge handshake. It first sends the normalization bit and then the data bytes. After those it sends the optional CRC byte and finally an EOD symbol.

Each time a byte moves from the holder into the shifter, the block pulses a holder-empty interrupt so the host can supply the next byte. The host marks the last byte with an end request. The sequencer stops on an underrun, on a bus error or on lost arbitration, and clears the request bits when it does. When arbitration is lost in the final two bit times of a byte, it sends two extra logic-1 bits so the bus sees a byte-boundary fault. The CRC arithmetic and the bit-level line encoding are handled elsewhere.

Top module: `ifr_tx_seq`

## Requirements
- R1: A request bit (`req_crc`, `req_nocrc`) is set by its host pulse only while `rx_in_frame` is high and the sequencer is idle. A pulse at any other time leaves the bit at 0, and a following `eod_rx` sends no symbol.
- R2: On `eod_rx` with `crc_ok` high and a request armed, the first symbol is the normalization symbol (`sym_kind` 0), followed by a data symbol (`sym_kind` 1) carrying the held byte. On `eod_rx` with `crc_ok` low, no symbol is sent and both request bits clear.
- R3: `tdre_irq` is a one-cycle pulse in the cycle after a byte moves into the shifter, while that byte's data symbol is being requested. No pulse is given when the end request is already set at that move.
- R4: At a reload with the end request set and the holder empty, CRC mode sends a CRC symbol (`sym_kind` 2) and then EOD (`sym_kind` 3). No-CRC mode sends EOD directly. If both request bits are set, CRC mode is used.
- R5: A single-byte IFR with CRC, where the host sets the end request at the first interrupt, sends exactly normalization, data, CRC and EOD, with one `tdre_irq` pulse.
- R6: At a reload with the holder empty and no end request (underrun), no further symbol is requested and both request bits clear.
- R7: Acknowledgement of the EOD symbol returns the sequencer to idle with both request bits cleared.
- R8: `bus_err` during an IFR drops `sym_req` in the next cycle and clears both request bits.
- R9: `arb_lost` during a data or CRC symbol at a bit index below `DATA_W-2` does the following:
  - drops `sym_req` in the next cycle;
  - sets `arb_lost_flag` and clears both request bits;
  - discards any byte waiting in the holder, so a later IFR with no new write underruns after the normalization symbol.
- R10: `arb_lost` during a data or CRC symbol at a bit index of `DATA_W-2` or above causes exactly one extra symbol, two logic-1 bits (`sym_kind` 4), and then idle.
- R11: `arb_lost_flag` stays set until a `host_clr_arb` pulse clears it.
- R12: While `sym_req` is high and no ack, bus error or arbitration loss occurs, `sym_req`, `sym_kind` and `sym_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write pulse for the data holder |
| host_wdata | input | DATA_W | Byte written into the holder |
| host_set_crc_req | input | 1 | Arm an IFR ending with a CRC byte |
| host_set_nocrc_req | input | 1 | Arm an IFR without a CRC byte |
| host_set_end | input | 1 | Mark the last written byte as the final IFR byte |
| host_clr_arb | input | 1 | Write-one-to-clear for the arbitration flag |
| rx_in_frame | input | 1 | High while a frame is received, before its EOD |
| eod_rx | input | 1 | Pulse: EOD symbol received |
| crc_ok | input | 1 | Received frame CRC good, valid with `eod_rx` |
| bus_err | input | 1 | Pulse: bus error detected |
| arb_lost | input | 1 | Pulse from transmitter: arbitration lost |
| arb_bit | input | $clog2(DATA_W) | Bit index at which arbitration was lost |
| sym_ack | input | 1 | Pulse from transmitter: current symbol done |
| sym_req | output | 1 | Symbol request to transmitter |
| sym_kind | output | 3 | 0 normalization, 1 data, 2 CRC, 3 EOD, 4 two 1 bits |
| sym_byte | output | DATA_W | Byte for a data symbol |
| req_crc | output | 1 | CRC-mode request bit |
| req_nocrc | output | 1 | No-CRC-mode request bit |
| arb_lost_flag | output | 1 | Sticky lost-arbitration flag |
| tdre_irq | output | 1 | Holder-empty interrupt pulse |

## Verification
The hardest case to reach is arbitration loss inside a specific byte at a specific bit index, with the next byte already waiting in the holder. Reaching it needs the transmitter, the host and the bus to be in step. The bench's transmitter model numbers each symbol it accepts and can replace the acknowledgement of a chosen symbol with an arbitration-loss pulse at a chosen bit index. Because the host model keeps writing on every interrupt, the holder is full at the moment of loss. A later frame armed without any write then shows whether the pending byte was discarded.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  typedef enum logic [2:0] {
    SYM_NORM = 3'd0,
    SYM_DATA = 3'd1,
    SYM_CRC  = 3'd2,
    SYM_EOD  = 3'd3,
    SYM_ONES = 3'd4
  } sym_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_NORM,
    ST_DATA,
    ST_CRC,
    ST_EOD,
    ST_ONES
  } seq_state_e;
endpackage

// File: rtl/ifr_rst_sync.sv
module ifr_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ifr_req_ctrl.sv
module ifr_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_idle,
  input  logic rx_in_frame,
  input  logic set_crc,
  input  logic set_nocrc,
  input  logic set_end,
  input  logic clr_req,
  input  logic arb_set,
  input  logic clr_arb,
  output logic req_crc,
  output logic req_nocrc,
  output logic end_req,
  output logic arb_flag
);
  logic crc_q, crc_d, nocrc_q, nocrc_d, end_q, end_d, arb_q, arb_d;
  logic arm_ok;

  assign arm_ok = seq_idle && rx_in_frame;

  always_comb begin
    crc_d   = crc_q;
    nocrc_d = nocrc_q;
    end_d   = end_q;
    arb_d   = arb_q;
    if (clr_req) begin
      crc_d   = 1'b0;
      nocrc_d = 1'b0;
      end_d   = 1'b0;
    end else begin
      if (set_crc && arm_ok)      crc_d   = 1'b1;
      if (set_nocrc && arm_ok)    nocrc_d = 1'b1;
      if (set_end && !seq_idle)   end_d   = 1'b1;
    end
    if (arb_set)      arb_d = 1'b1;
    else if (clr_arb) arb_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q   <= 1'b0;
      nocrc_q <= 1'b0;
      end_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      crc_q   <= crc_d;
      nocrc_q <= nocrc_d;
      end_q   <= end_d;
      arb_q   <= arb_d;
    end
  end

  assign req_crc   = crc_q;
  assign req_nocrc = nocrc_q;
  assign end_req   = end_q;
  assign arb_flag  = arb_q;
endmodule

// File: rtl/ifr_data_hold.sv
module ifr_data_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  input  logic              flush,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    full_d = full_q;
    if (wr)                 full_d = 1'b1;
    else if (take || flush) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  data_q <= '0;
    else if (wr) data_q <= wdata;
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/ifr_seq_fsm.sv
module ifr_seq_fsm #(
  parameter int DATA_W    = 8,
  parameter int TAIL_BITS = 2,
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eod_rx,
  input  logic              crc_ok,
  input  logic              req_crc,
  input  logic              req_nocrc,
  input  logic              end_req,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              bus_err,
  input  logic              arb_lost,
  input  logic [BIT_W-1:0]  arb_bit,
  input  logic              sym_ack,
  output logic              sym_req,
  output logic [2:0]        sym_kind,
  output logic [DATA_W-1:0] sym_byte,
  output logic              take,
  output logic              flush,
  output logic              clr_req,
  output logic              arb_set,
  output logic              tdre_irq,
  output logic              seq_idle
);
  import ifr_pkg::*;

  localparam logic [BIT_W-1:0] TAIL_START = BIT_W'(DATA_W - TAIL_BITS);

  seq_state_e        state_q, state_d;
  logic              mode_q, mode_d;
  logic              tdre_q, tdre_d;
  logic              reload;
  logic [DATA_W-1:0] shift_q;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    tdre_d  = 1'b0;
    take    = 1'b0;
    flush   = 1'b0;
    clr_req = 1'b0;
    arb_set = 1'b0;
    reload  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (eod_rx) begin
          if (crc_ok && (req_crc || req_nocrc)) begin
            state_d = ST_NORM;
            mode_d  = req_crc;
          end else begin
            clr_req = 1'b1;
          end
        end
      end
      ST_NORM: begin
        if (bus_err) begin
          clr_req = 1'b1;
          state_d = ST_IDLE;
        end else if (sym_ack) begin
          reload = 1'b1;
        end
      end
      ST_DATA, ST_CRC: begin
        if (bus_err) begin
          clr_req = 1'b1;
          flush   = 1'b1;
          state_d = ST_IDLE;
        end else if (arb_lost) begin
          arb_set = 1'b1;
          clr_req = 1'b1;
          flush   = 1'b1;
          state_d = (arb_bit >= TAIL_START) ? ST_ONES : ST_IDLE;
        end else if (sym_ack) begin
          if (state_q == ST_DATA) reload  = 1'b1;
          else                    state_d = ST_EOD;
        end
      end
      ST_EOD: begin
        if (bus_err || sym_ack) begin
          clr_req = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_ONES: begin
        if (bus_err || sym_ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase

    if (reload) begin
      if (hold_full) begin
        take    = 1'b1;
        tdre_d  = !end_req;
        state_d = ST_DATA;
      end else if (end_req) begin
        state_d = mode_q ? ST_CRC : ST_EOD;
      end else begin
        clr_req = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      tdre_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      tdre_q  <= tdre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shift_q <= '0;
    else if (take) shift_q <= hold_data;
  end

  always_comb begin
    unique case (state_q)
      ST_NORM: sym_kind = SYM_NORM;
      ST_DATA: sym_kind = SYM_DATA;
      ST_CRC:  sym_kind = SYM_CRC;
      ST_EOD:  sym_kind = SYM_EOD;
      ST_ONES: sym_kind = SYM_ONES;
      default: sym_kind = SYM_NORM;
    endcase
  end

  assign sym_req  = (state_q != ST_IDLE);
  assign seq_idle = (state_q == ST_IDLE);
  assign sym_byte = shift_q;
  assign tdre_irq = tdre_q;
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq #(
  parameter int DATA_W    = 8,
  parameter int TAIL_BITS = 2,
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_set_crc_req,
  input  logic              host_set_nocrc_req,
  input  logic              host_set_end,
  input  logic              host_clr_arb,
  input  logic              rx_in_frame,
  input  logic              eod_rx,
  input  logic              crc_ok,
  input  logic              bus_err,
  input  logic              arb_lost,
  input  logic [BIT_W-1:0]  arb_bit,
  input  logic              sym_ack,
  output logic              sym_req,
  output logic [2:0]        sym_kind,
  output logic [DATA_W-1:0] sym_byte,
  output logic              req_crc,
  output logic              req_nocrc,
  output logic              arb_lost_flag,
  output logic              tdre_irq
);
  logic              rst_s;
  logic              seq_idle, end_req, clr_req, arb_set;
  logic              take, flush, hold_full;
  logic [DATA_W-1:0] hold_data;

  ifr_rst_sync rst_sync_i (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s)
  );

  ifr_req_ctrl req_ctrl_i (
    .clk         (clk),
    .rst_n       (rst_s),
    .seq_idle    (seq_idle),
    .rx_in_frame (rx_in_frame),
    .set_crc     (host_set_crc_req),
    .set_nocrc   (host_set_nocrc_req),
    .set_end     (host_set_end),
    .clr_req     (clr_req),
    .arb_set     (arb_set),
    .clr_arb     (host_clr_arb),
    .req_crc     (req_crc),
    .req_nocrc   (req_nocrc),
    .end_req     (end_req),
    .arb_flag    (arb_lost_flag)
  );

  ifr_data_hold #(.DATA_W(DATA_W)) hold_i (
    .clk   (clk),
    .rst_n (rst_s),
    .wr    (host_wr),
    .wdata (host_wdata),
    .take  (take),
    .flush (flush),
    .full  (hold_full),
    .data  (hold_data)
  );

  ifr_seq_fsm #(.DATA_W(DATA_W), .TAIL_BITS(TAIL_BITS)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_s),
    .eod_rx    (eod_rx),
    .crc_ok    (crc_ok),
    .req_crc   (req_crc),
    .req_nocrc (req_nocrc),
    .end_req   (end_req),
    .hold_full (hold_full),
    .hold_data (hold_data),
    .bus_err   (bus_err),
    .arb_lost  (arb_lost),
    .arb_bit   (arb_bit),
    .sym_ack   (sym_ack),
    .sym_req   (sym_req),
    .sym_kind  (sym_kind),
    .sym_byte  (sym_byte),
    .take      (take),
    .flush     (flush),
    .clr_req   (clr_req),
    .arb_set   (arb_set),
    .tdre_irq  (tdre_irq),
    .seq_idle  (seq_idle)
  );
endmodule

// File: rtl/ifr_tx_seq_chk.sv
module ifr_tx_seq_chk #(
  parameter int DATA_W    = 8,
  parameter int TAIL_BITS = 2,
  localparam int BIT_W    = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_in_frame,
  input logic              host_clr_arb,
  input logic              bus_err,
  input logic              arb_lost,
  input logic [BIT_W-1:0]  arb_bit,
  input logic              sym_ack,
  input logic              sym_req,
  input logic [2:0]        sym_kind,
  input logic [DATA_W-1:0] sym_byte,
  input logic              req_crc,
  input logic              req_nocrc,
  input logic              arb_lost_flag,
  input logic              tdre_irq
);
  import ifr_pkg::*;

  localparam logic [BIT_W-1:0] TAIL_START = BIT_W'(DATA_W - TAIL_BITS);

  logic in_byte;
  assign in_byte = sym_req && (sym_kind == SYM_DATA || sym_kind == SYM_CRC);

  assert_late_crc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_in_frame && !req_crc) |=> !req_crc);
  assert_late_nocrc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_in_frame && !req_nocrc) |=> !req_nocrc);
  assert_tdre_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tdre_irq |-> (sym_req && sym_kind == SYM_DATA));
  assert_eod_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && sym_kind == SYM_EOD && sym_ack && !bus_err) |=> (!sym_req && !req_crc && !req_nocrc));
  assert_bus_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && sym_req) |=> (!sym_req && !req_crc && !req_nocrc));
  assert_arb_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && arb_lost && !bus_err && arb_bit < TAIL_START) |=>
      (!sym_req && arb_lost_flag && !req_crc && !req_nocrc));
  assert_arb_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && arb_lost && !bus_err && arb_bit >= TAIL_START) |=>
      (sym_req && sym_kind == SYM_ONES && arb_lost_flag));
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost_flag && !host_clr_arb) |=> arb_lost_flag);
  assert_sym_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && !sym_ack && !bus_err && !arb_lost) |=>
      (sym_req && $stable(sym_kind) && $stable(sym_byte)));
endmodule

bind ifr_tx_seq ifr_tx_seq_chk #(.DATA_W(DATA_W), .TAIL_BITS(TAIL_BITS)) chk_i (
  .clk           (clk),
  .rst_n         (rst_s),
  .rx_in_frame   (rx_in_frame),
  .host_clr_arb  (host_clr_arb),
  .bus_err       (bus_err),
  .arb_lost      (arb_lost),
  .arb_bit       (arb_bit),
  .sym_ack       (sym_ack),
  .sym_req       (sym_req),
  .sym_kind      (sym_kind),
  .sym_byte      (sym_byte),
  .req_crc       (req_crc),
  .req_nocrc     (req_nocrc),
  .arb_lost_flag (arb_lost_flag),
  .tdre_irq      (tdre_irq)
);

// File: tb/ifr_tx_seq_tb_top.sv
module ifr_tx_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int BIT_W      = $clog2(DATA_W);
  localparam int LAT        = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              host_wr = 1'b0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic              host_set_crc_req = 1'b0;
  logic              host_set_nocrc_req = 1'b0;
  logic              host_set_end = 1'b0;
  logic              host_clr_arb = 1'b0;
  logic              rx_in_frame = 1'b0;
  logic              eod_rx = 1'b0;
  logic              crc_ok = 1'b0;
  logic              bus_err = 1'b0;
  logic              arb_lost = 1'b0;
  logic [BIT_W-1:0]  arb_bit = '0;
  logic              sym_ack = 1'b0;
  logic              sym_req;
  logic [2:0]        sym_kind;
  logic [DATA_W-1:0] sym_byte;
  logic              req_crc, req_nocrc, arb_lost_flag, tdre_irq;

  int n_checks = 0;
  int n_errors = 0;

  // transmitter model state and symbol log
  bit m_busy = 1'b0;
  int m_cnt = 0;
  int log_n = 0;
  int log_kind [64];
  int log_byte [64];
  int arb_at = -1;
  int arb_bitv = 0;
  int tdre_n = 0;
  int xb [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  ifr_tx_seq #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_set_crc_req(host_set_crc_req), .host_set_nocrc_req(host_set_nocrc_req),
    .host_set_end(host_set_end), .host_clr_arb(host_clr_arb),
    .rx_in_frame(rx_in_frame), .eod_rx(eod_rx), .crc_ok(crc_ok),
    .bus_err(bus_err), .arb_lost(arb_lost), .arb_bit(arb_bit), .sym_ack(sym_ack),
    .sym_req(sym_req), .sym_kind(sym_kind), .sym_byte(sym_byte),
    .req_crc(req_crc), .req_nocrc(req_nocrc), .arb_lost_flag(arb_lost_flag),
    .tdre_irq(tdre_irq)
  );

  always @(negedge clk) begin
    sym_ack  = 1'b0;
    arb_lost = 1'b0;
    if (tdre_irq) tdre_n++;
    if (m_busy && !sym_req) begin
      m_busy = 1'b0;
    end else if (m_busy) begin
      if (m_cnt >= LAT) begin
        m_busy = 1'b0;
        if (log_n - 1 == arb_at) begin
          arb_lost = 1'b1;
          arb_bit  = BIT_W'(arb_bitv);
        end else begin
          sym_ack = 1'b1;
        end
      end else begin
        m_cnt++;
      end
    end else if (sym_req && rst_n) begin
      m_busy = 1'b1;
      m_cnt  = 0;
      if (log_n < 64) begin
        log_kind[log_n] = int'(sym_kind);
        log_byte[log_n] = int'(sym_byte);
      end
      log_n++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_tdre(int n);
    return (n == 1) ? 1 : n - 1;
  endfunction

  function automatic int exp_len(int n, bit crc);
    return 1 + n + (crc ? 1 : 0) + 1;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_tdre();
    int t = 0;
    while (!tdre_irq && t < LAT * 6) begin
      tick();
      t++;
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    repeat (LAT + 4) tick();
    while (sym_req && t < 1000) begin
      tick();
      t++;
    end
    repeat (2) tick();
  endtask

  // arm a request, optionally write the first byte, deliver EOD, serve interrupts
  task automatic run_frame(int n, bit crc, bit w0, bit underrun);
    log_n  = 0;
    tdre_n = 0;
    for (int i = 0; i < 4; i++) xb[i] = int'($urandom_range(0, 255));
    tick();
    rx_in_frame = 1'b1;
    if (w0) begin
      host_wr    = 1'b1;
      host_wdata = DATA_W'(xb[0]);
    end
    tick();
    host_wr = 1'b0;
    if (crc) host_set_crc_req = 1'b1;
    else     host_set_nocrc_req = 1'b1;
    tick();
    host_set_crc_req   = 1'b0;
    host_set_nocrc_req = 1'b0;
    rx_in_frame        = 1'b0;
    tick();
    eod_rx = 1'b1;
    crc_ok = 1'b1;
    tick();
    eod_rx = 1'b0;
    if (!underrun && w0) begin
      if (n == 1) begin
        wait_tdre();
        host_set_end = 1'b1;
        tick();
        host_set_end = 1'b0;
      end else begin
        for (int i = 1; i < n; i++) begin
          wait_tdre();
          host_wr    = 1'b1;
          host_wdata = DATA_W'(xb[i]);
          if (i == n - 1) host_set_end = 1'b1;
          tick();
          host_wr      = 1'b0;
          host_set_end = 1'b0;
        end
      end
    end
    wait_idle();
  endtask

  task automatic check_frame(string tag, int n, bit crc);
    chk({tag, " length"}, log_n, exp_len(n, crc));
    chk({tag, " first is normalization R2"}, log_kind[0], 0);
    for (int i = 0; i < n; i++) begin
      chk({tag, " data kind"}, log_kind[1 + i], 1);
      chk({tag, " data byte"}, log_byte[1 + i], xb[i]);
    end
    if (crc) chk({tag, " crc kind R4"}, log_kind[1 + n], 2);
    chk({tag, " eod kind R4"}, log_kind[exp_len(n, crc) - 1], 3);
    chk({tag, " interrupt count R3"}, tdre_n, exp_tdre(n));
    chk({tag, " requests cleared R7"}, int'(req_crc) + int'(req_nocrc), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int seed;
    int n;
    bit crc;
    seed = $urandom(32'h1850);
    repeat (5) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // reset state
    chk("reset sym_req", int'(sym_req), 0);
    chk("reset requests", int'(req_crc) + int'(req_nocrc), 0);
    chk("reset arb flag", int'(arb_lost_flag), 0);
    chk("reset tdre", int'(tdre_irq), 0);

    // R1: late request is ignored and no IFR follows
    log_n = 0;
    rx_in_frame = 1'b0;
    host_set_crc_req = 1'b1;
    tick();
    host_set_crc_req = 1'b0;
    tick();
    chk("R1 late request bit", int'(req_crc), 0);
    eod_rx = 1'b1; crc_ok = 1'b1;
    tick();
    eod_rx = 1'b0;
    repeat (LAT) tick();
    chk("R1 no symbol after late request", log_n, 0);

    // R2: bad CRC at EOD sends nothing and clears the request
    rx_in_frame = 1'b1;
    host_set_nocrc_req = 1'b1;
    tick();
    host_set_nocrc_req = 1'b0;
    rx_in_frame = 1'b0;
    tick();
    chk("R2 request armed", int'(req_nocrc), 1);
    eod_rx = 1'b1; crc_ok = 1'b0;
    tick();
    eod_rx = 1'b0;
    repeat (LAT) tick();
    chk("R2 bad crc no symbol", log_n, 0);
    chk("R2 bad crc clears request", int'(req_nocrc), 0);

    // R5: single byte with CRC
    run_frame(1, 1'b1, 1'b1, 1'b0);
    check_frame("R5 single", 1, 1'b1);

    // R4: no-CRC multi byte
    run_frame(3, 1'b0, 1'b1, 1'b0);
    check_frame("R4 nocrc", 3, 1'b0);

    // R6: underrun after the first byte
    run_frame(3, 1'b1, 1'b1, 1'b1);
    chk("R6 underrun length", log_n, 2);
    chk("R6 underrun data byte", log_byte[1], xb[0]);
    chk("R6 underrun clears requests", int'(req_crc) + int'(req_nocrc), 0);

    // R8: bus error during a data byte
    log_n = 0;
    tdre_n = 0;
    tick();
    rx_in_frame = 1'b1; host_wr = 1'b1; host_wdata = 8'h5A;
    tick();
    host_wr = 1'b0; host_set_crc_req = 1'b1;
    tick();
    host_set_crc_req = 1'b0; rx_in_frame = 1'b0;
    eod_rx = 1'b1; crc_ok = 1'b1;
    tick();
    eod_rx = 1'b0;
    while (log_n < 2) tick();
    repeat (3) tick();
    bus_err = 1'b1;
    tick();
    bus_err = 1'b0;
    chk("R8 request dropped", int'(sym_req), 0);
    chk("R8 requests cleared", int'(req_crc) + int'(req_nocrc), 0);
    wait_idle();

    // R9: early arbitration loss in second data byte, pending byte discarded
    arb_at = 2; arb_bitv = 3;
    run_frame(3, 1'b1, 1'b1, 1'b0);
    arb_at = -1;
    chk("R9 stops after lost byte", log_n, 3);
    chk("R9 flag set", int'(arb_lost_flag), 1);
    chk("R9 requests cleared", int'(req_crc) + int'(req_nocrc), 0);
    run_frame(2, 1'b1, 1'b0, 1'b0);
    chk("R9 pending byte not retried", log_n, 1);

    // R11: flag sticky, then cleared by host
    chk("R11 flag still set", int'(arb_lost_flag), 1);
    host_clr_arb = 1'b1;
    tick();
    host_clr_arb = 1'b0;
    tick();
    chk("R11 flag cleared", int'(arb_lost_flag), 0);

    // R10: late arbitration loss in a data byte forces two 1 bits
    arb_at = 1; arb_bitv = DATA_W - 2;
    run_frame(2, 1'b0, 1'b1, 1'b0);
    arb_at = -1;
    chk("R10 data tail length", log_n, 3);
    chk("R10 ones symbol kind", log_kind[2], 4);
    chk("R10 flag", int'(arb_lost_flag), 1);

    // R10: late arbitration loss in the CRC byte
    arb_at = 2; arb_bitv = DATA_W - 1;
    run_frame(1, 1'b1, 1'b1, 1'b0);
    arb_at = -1;
    chk("R10 crc tail length", log_n, 4);
    chk("R10 crc then ones", log_kind[2] * 10 + log_kind[3], 24);
    host_clr_arb = 1'b1;
    tick();
    host_clr_arb = 1'b0;

    // random frames, R12 byte integrity via logged bytes
    for (int k = 0; k < 40; k++) begin
      n   = int'($urandom_range(1, 4));
      crc = 1'($urandom_range(0, 1));
      run_frame(n, crc, 1'b1, 1'b0);
      check_frame("R12 random", n, crc);
    end
    chk("R11 flag untouched by clean frames", int'(arb_lost_flag), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule